// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog peripheral on a simple single-cycle register bus. It has an address, a write strobe, write data and combinational read data. A 32-bit down-counter steps once for every sixteen bus clocks. When the count passes through zero for the first time, the block raises an interrupt. If software has not serviced that interrupt by the next pass through zero, the block raises a reset request, provided reset is enabled. Software services the watchdog by writing the interrupt-clear register. That write drops the interrupt and restarts the count from the load value.

Every control register is guarded by a write lock. Writing a fixed 32-bit key to the lock register opens the bank. Any other value written there closes it. While the bank is closed, writes to the load, control and clear registers are dropped without effect. The lock register itself always accepts writes. The bank leaves reset unlocked and the counter stopped.

Top module: `wdog_top`

## Requirements
- R1: After reset, wd_irq and wd_rst_req are 0. The lock register (0xC00) reads 0 and the control register (0x008) reads 0. The load register (0x000) reads 0xFFFFFFFF.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the bank, and 0xC00 then reads 0. Writing any other value locks it, and 0xC00 then reads 1.
- R3: While the bank is locked, writes to 0x000, 0x008 and 0x00C have no effect: readback is unchanged and a pending wd_irq stays high.
- R4: The load register at 0x000 reads back the last 32-bit value written. The control register at 0x008 reads back bits [1:0] of the last write, with the upper bits 0. Offset 0x00C and unmapped offsets read 0.
- R5: With control bit 0 (enable) set and load value L, wd_irq rises exactly 16*(L+1) clocks after the write that enabled the counter or reloaded it.
- R6: An unlocked write of any value to 0x00C lowers wd_irq by the next cycle. It also restarts the count, so that wd_irq next rises 16*(L+1) clocks after that write.
- R7: If wd_irq is still high at the next expiry and control bit 1 (reset enable) is set, wd_rst_req rises 16*(L+1) clocks after wd_irq rose. It then stays high until rst_n is asserted.
- R8: With control bit 1 clear, the second expiry leaves wd_rst_req low and wd_irq high.
- R9: Clearing control bit 0 stops the counter and clears wd_irq. No further expiry occurs while the counter is stopped.
- R10: An unlocked write to 0x000 reloads the counter at once. The next expiry falls 16*(L+1) clocks after that write, using the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| wd_irq | output | 1 | Registered first-expiry interrupt, active high |
| wd_rst_req | output | 1 | Registered sticky reset request, active high |

## Verification
Read data is combinational. The bench samples it at the falling edge, with the address held, and sees register effects at the first falling edge after the write's rising edge. The interrupt and reset request are registered. Each is due a fixed 16*(L+1) rising edges after the enabling write, the reload write or the previous expiry. The bench counts falling edges from that write and checks that the output is still low one cycle early and high exactly on time. A clearing write is checked one cycle after it takes effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_KICK = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_LOCK = 12'hC00;
  localparam logic [DATA_W-1:0] OPEN_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run || restart || phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick = run && !restart && (phase == LAST);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  reload_val,
  output logic              reload,
  output logic              kick,
  output logic              locked
);
  logic wr_ok;
  logic wr_load;
  logic wr_ctrl;

  assign wr_ok   = bus_we && !locked;
  assign wr_load = wr_ok && (bus_addr == OFS_LOAD);
  assign wr_ctrl = wr_ok && (bus_addr == OFS_CTRL);
  assign kick    = wr_ok && (bus_addr == OFS_KICK);
  assign reload  = wr_load || kick;
  assign reload_val = wr_load ? bus_wdata[CNT_W-1:0] : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      ctrl     <= '0;
      load_val <= '1;
    end else begin
      if (bus_we && bus_addr == OFS_LOCK) locked <= (bus_wdata != OPEN_KEY);
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[1:0]);
      if (wr_load) load_val <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LOAD: bus_rdata[CNT_W-1:0] = load_val;
      OFS_CTRL: bus_rdata[1:0] = ctrl;
      OFS_LOCK: bus_rdata[0] = locked;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic             tick,
  input  logic             reload,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] load_val,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] count;
  logic             expire;

  assign expire = tick && !reload && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '1;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (reload) begin
        count <= reload_val;
      end else if (tick) begin
        count <= (count == '0) ? load_val : count - 1'b1;
      end

      if (kick || !run) begin
        irq <= 1'b0;
      end else if (expire) begin
        irq <= 1'b1;
      end

      if (expire && irq && rst_en) rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst_req
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload_val;
  logic             reload;
  logic             kick;
  logic             locked;
  logic             tick;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctrl       (ctrl),
    .load_val   (load_val),
    .reload_val (reload_val),
    .reload     (reload),
    .kick       (kick),
    .locked     (locked)
  );

  wdog_prescale #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .restart (reload),
    .tick    (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.run),
    .rst_en     (ctrl.rst_en),
    .tick       (tick),
    .reload     (reload),
    .kick       (kick),
    .reload_val (reload_val),
    .load_val   (load_val),
    .irq        (wd_irq),
    .rst_req    (wd_rst_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              locked,
  input logic [1:0]        ctrl_bits,
  input logic              irq,
  input logic              rst_req
);
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R7

  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq)); // R7

  AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && locked && bus_addr == OFS_CTRL) |=> ctrl_bits == $past(ctrl_bits)); // R3

  AST_KICK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !locked && bus_addr == OFS_KICK) |=> !irq); // R6

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_bits[0])); // R5

  AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[0] |=> !irq); // R9
endmodule

bind wdog_top wdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .locked    (locked),
  .ctrl_bits (ctrl),
  .irq       (wd_irq),
  .rst_req   (wd_rst_req)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  localparam logic [11:0] A_LOAD = 12'h000;
  localparam logic [11:0] A_CTRL = 12'h008;
  localparam logic [11:0] A_KICK = 12'h00C;
  localparam logic [11:0] A_LOCK = 12'hC00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_irq;
  logic        wd_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
  );

  always #2.5 clk = ~clk;

  function automatic int due(input int l);
    return 16 * (l + 1);
  endfunction

  function automatic logic lock_after(input logic [31:0] v);
    return (v != KEY);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic reset_state_check();
    logic [31:0] v;
    chk("R1 irq", {31'b0, wd_irq}, 0);
    chk("R1 rst_req", {31'b0, wd_rst_req}, 0);
    rd(A_LOCK, v); chk("R1 lock", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 32'hFFFFFFFF);
  endtask

  // Waits until one cycle before the due edge, checks low, then checks high.
  task automatic expect_rise(input string req, input int n, input bit is_rst);
    wait_n(n - 1);
    chk(req, {31'b0, is_rst ? wd_rst_req : wd_irq}, 0);
    wait_n(1);
    chk(req, {31'b0, is_rst ? wd_rst_req : wd_irq}, 1);
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    reset_state_check();

    // R2 lock key handling
    wr(A_LOCK, 32'h1); rd(A_LOCK, v); chk("R2 lock", v, 1);
    wr(A_LOCK, KEY); rd(A_LOCK, v); chk("R2 unlock", v, 0);
    wr(A_LOCK, KEY ^ 32'h1); rd(A_LOCK, v); chk("R2 near key", v, 1);
    wr(A_LOCK, KEY); rd(A_LOCK, v); chk("R2 unlock again", v, 0);

    // R4 readback
    wr(A_LOAD, 32'h12345678); rd(A_LOAD, v); chk("R4 load", v, 32'h12345678);
    wr(A_CTRL, 32'hFFFFFFFE); rd(A_CTRL, v); chk("R4 ctrl", v, 2);
    wr(A_CTRL, 0);
    rd(A_KICK, v); chk("R4 kick reads 0", v, 0);
    rd(12'h004, v); chk("R4 unmapped", v, 0);

    // R5 first expiry, R6 kick, R7 reset request
    wr(A_LOAD, 3);
    wr(A_CTRL, 3);
    expect_rise("R5 irq timing", due(3), 0);
    wait_n(10);
    wr(A_KICK, 32'hDEAD);
    chk("R6 irq cleared", {31'b0, wd_irq}, 0);
    expect_rise("R6 irq after kick", due(3), 0);
    expect_rise("R7 rst_req timing", due(3), 1);
    wait_n(40);
    chk("R7 rst sticky", {31'b0, wd_rst_req}, 1);
    do_reset();
    @(negedge clk);
    reset_state_check();

    // R8 no reset when bit 1 clear
    wr(A_LOAD, 2);
    wr(A_CTRL, 1);
    expect_rise("R8 irq", due(2), 0);
    wait_n(due(2) + 5);
    chk("R8 no rst", {31'b0, wd_rst_req}, 0);
    chk("R8 irq held", {31'b0, wd_irq}, 1);

    // R3 locked writes ignored
    wr(A_LOCK, 32'h0);
    wr(A_KICK, 0);
    chk("R3 kick ignored", {31'b0, wd_irq}, 1);
    wr(A_CTRL, 0); rd(A_CTRL, v); chk("R3 ctrl held", v, 1);
    wr(A_LOAD, 9); rd(A_LOAD, v); chk("R3 load held", v, 2);
    wr(A_LOCK, KEY);

    // R9 stop
    wr(A_CTRL, 0);
    @(negedge clk);
    chk("R9 irq cleared", {31'b0, wd_irq}, 0);
    wait_n(200);
    chk("R9 no expiry", {31'b0, wd_irq}, 0);

    // R10 load write reloads
    wr(A_LOAD, 5);
    wr(A_CTRL, 1);
    wait_n(20);
    wr(A_LOAD, 1);
    expect_rise("R10 reload", due(1), 0);

    // Random: load values and lock keys
    for (int it = 0; it < 16; it++) begin
      int l;
      logic [31:0] key;
      l = $urandom % 7;
      wr(A_CTRL, 0);
      wr(A_LOAD, l);
      wr(A_CTRL, 1);
      expect_rise("R5 random load", due(l), 0);
      key = ($urandom % 2) ? KEY : $urandom;
      wr(A_LOCK, key);
      rd(A_LOCK, v);
      chk("R2 random key", v, {31'b0, lock_after(key)});
      wr(A_LOCK, KEY);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule